// File: doc/BRIEF.md
# Bit Deposit and Extract Unit

This block performs the two mask-steered bit scatter and gather operations on a data word of `W` bits (64 by default). In deposit mode the lowest bits of the source are spread, in order, over the bit positions where the mask holds a one. In extract mode the source bits found at the mask's one positions are collected and packed, in order, at the low end of the result. The destination of each bit depends on how many mask ones lie below it, not on a fixed shift amount.

The unit is iterative. It visits one mask position per clock, from bit 0 upward, and keeps a running count of the mask ones seen so far. A caller pulses `start` with the operands and waits for the one-cycle `done` pulse, which arrives `W` cycles later. A wider vector datapath would place one copy of this unit in each 64-bit lane.

Top module: `bit_scatter_gather`

## Requirements
- R1: With `op_extract`=0 (deposit), for each mask bit i that is one, result bit i equals source bit j. Here j is the number of mask ones below position i.
- R2: With `op_extract`=1 (extract), for each mask bit i that is one, result bit j equals source bit i. Here j is the number of mask ones below position i.
- R3: Every result bit that no mask one writes is zero.
- R4: When `start` is accepted while idle, `busy` is high for exactly `W` cycles. The result appears together with `done` `W` cycles after the accepting edge.
- R5: A `start` pulse while `busy` is high is ignored. The running operation finishes with its original operands and timing.
- R6: `done` is high for exactly one cycle per operation, and `done` and `busy` are never high together.
- R7: `result` holds its value from one `done` pulse until the next, whatever the inputs do in between.
- R8: An all-zero mask gives an all-zero result in both modes.
- R9: An all-ones mask returns the source unchanged in both modes.
- R10: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_extract | input | 1 | 0 = deposit, 1 = extract |
| src | input | W | Source data |
| mask | input | W | Selection mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Operation result, held until the next completion |

## Verification
The bench builds the unit with `W`=8. At that width all 256 masks can be swept in both modes, each with several source patterns, including all-ones, all-zeros and alternating values. This covers every running-count placement, the empty and full masks, and the edge positions 0 and `W`-1. It also checks the exact `W`-cycle latency and the pulse shape on every operation. The narrow width also leaves room to inject stray `start` pulses mid-operation and to toggle the inputs after completion.

// File: rtl/bit_scatter_gather.sv
module bit_scatter_gather #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_extract,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  src_q, mask_q, acc, acc_nxt;
  logic          op_q;
  logic [IW-1:0] pos, ones;
  logic          last;

  assign last = (pos == IW'(W - 1));

  always_comb begin
    acc_nxt = acc;
    if (mask_q[pos]) begin
      if (op_q) acc_nxt[ones] = src_q[pos];
      else      acc_nxt[pos]  = src_q[ones];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
      acc    <= '0;
      op_q   <= 1'b0;
      pos    <= '0;
      ones   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          src_q  <= src;
          mask_q <= mask;
          op_q   <= op_extract;
          acc    <= '0;
          pos    <= '0;
          ones   <= '0;
          busy   <= 1'b1;
        end
      end else begin
        acc <= acc_nxt;
        pos <= pos + 1'b1;
        if (mask_q[pos]) ones <= ones + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= acc_nxt;
        end
      end
    end
  end

  // R6
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(src_q) && $stable(mask_q) && $stable(op_q)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mask_q == '0) |=> (acc == '0));
endmodule

// File: tb/bit_scatter_gather_bench.sv
module bit_scatter_gather_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_extract = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] mask = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bit_scatter_gather #(.W(W)) u_bit_scatter_gather (
    .clk(clk), .rst_n(rst_n), .start(start), .op_extract(op_extract),
    .src(src), .mask(mask), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [W-1:0] model(input logic ext, input logic [W-1:0] s,
                                         input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int j = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        if (ext) r[j] = s[i];
        else     r[i] = s[j];
        j++;
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic ext, input logic [W-1:0] s, input logic [W-1:0] m,
                     input bit poke);
    logic [W-1:0] exp;
    bit bad;
    exp = model(ext, s, m);
    @(negedge clk);
    start = 1'b1; op_extract = ext; src = s; mask = m;
    @(negedge clk);
    start = 1'b0;
    bad = !(busy === 1'b1 && done === 1'b0);
    for (int k = 1; k < W; k++) begin
      if (poke && k == 3) begin
        start = 1'b1; op_extract = ~ext; src = ~s; mask = ~m;
      end
      @(negedge clk);
      start = 1'b0;
      if (!(busy === 1'b1 && done === 1'b0)) bad = 1'b1;
    end
    src = ~s; mask = ~m;
    @(negedge clk);
    check("R4 busy window", {7'd0, bad}, 8'd0);
    check("R4 done timing", {6'd0, done, busy}, 8'b10);
    if (m == '0)           check("R8 zero mask", result, '0);
    else if (m == '1)      check("R9 full mask", result, s);
    else if (s == '1)      check("R3 unwritten bits zero", result, exp);
    else if (poke)         check("R5 start while busy", result, exp);
    else if (ext)          check("R2 extract", result, exp);
    else                   check("R1 deposit", result, exp);
    @(negedge clk);
    check("R6 done pulse", {7'd0, done}, 8'd0);
    check("R7 result held", result, exp);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h3C; pats[3] = 8'h00;
    repeat (3) @(negedge clk);
    // R10
    check("R10 reset busy/done", {6'd0, busy, done}, 8'd0);
    check("R10 reset result", result, '0);
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 256; m++)
        for (int p = 0; p < 4; p++)
          run(e[0], pats[p], m[7:0], 1'b0);
    run(1'b0, 8'h5A, 8'hC6, 1'b1);
    run(1'b1, 8'h5A, 8'hC6, 1'b1);
    run(1'b0, 8'h81, 8'h81, 1'b1);
    // R7: idle with toggling inputs and no start
    repeat (5) begin
      @(negedge clk);
      src = ~src; mask = ~mask; op_extract = ~op_extract;
    end
    check("R7 result held while idle", result, model(1'b0, 8'h81, 8'h81));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule